// File: doc/BRIEF.md
# Cartridge Bank Latch with Selectable Page Order

This block lets a host that only sees a fixed 8 KiB cartridge window reach a much larger flash or ROM. A write cycle aimed at the window does not store data anywhere. The block takes a field of the host address as the new bank number and holds it. That bank then drives the upper address lines of the backing memory, while the 13 window offset bits pass straight through. A static configuration input selects the page order. In normal order bank n maps to page n. In inverted order bank n maps to page (2^BANK_BITS - 1 - n).

The host strobes are sampled on the block clock. A small state machine follows each write. S_IDLE waits for a write cycle in the window. On the edge that first sees the chip select and the write strobe both low, it moves to S_ARMED and captures the bank field. S_ARMED stays put while the strobe is low. On the edge that sees the strobe high it commits the captured bank and returns to S_IDLE. If the chip select rises while the strobe is still low, S_ARMED moves to S_DRAIN without committing. S_DRAIN returns to S_IDLE once the strobe is high. The block also passes the chip select to the memory. It holds the memory write-protected unless programming is enabled.

Top module: `cartbank_latch`

## Requirements
- R1: While reset is asserted and after it is released, the logical bank is 0. The upper memory address is therefore all zeros with normal order and all ones with inverted order.
- R2: A write cycle in the window (rom_cs_n low and rom_we_n low, both seen by the S_IDLE state) captures host_addr[BANK_LSB +: BANK_BITS] as the new bank. The block has no data input.
- R3: The upper memory address keeps its old value for as long as the strobe stays low. The new page appears after the clock edge that first samples rom_we_n high in S_ARMED.
- R4: With inv_order = 0 the upper memory address equals the bank. With inv_order = 1 it equals the bitwise complement of the bank, which is (2^BANK_BITS - 1 - bank). The mapping follows inv_order without waiting for a clock.
- R5: mem_addr[12:0] equals host_addr[12:0] combinationally.
- R6: A read cycle (rom_cs_n low, rom_we_n high) never changes the bank.
- R7: A write strobe while rom_cs_n is high never changes the bank.
- R8: If rom_cs_n rises while rom_we_n is still low, the cycle is dropped. The state machine enters S_DRAIN and leaves it only when rom_we_n is high, with the bank unchanged.
- R9: Only the address sampled on the edge that enters S_ARMED is used. Address changes later in the same strobe are ignored.
- R10: Host address bits outside the bank field (bit 0, and bits above BANK_LSB+BANK_BITS-1) have no effect on the bank.
- R11: mem_wp is 1 whenever prog_en is 0, and 0 whenever prog_en is 1.
- R12: mem_ce_n follows rom_cs_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 13 | Host address inside the 8 KiB window |
| rom_cs_n | input | 1 | Active-low host select of the cartridge window |
| rom_we_n | input | 1 | Active-low host write strobe |
| inv_order | input | 1 | 1 selects inverted page order |
| prog_en | input | 1 | 1 lifts write protection of the memory |
| mem_addr | output | BANK_BITS+13 | Backing memory address, with the page on top |
| mem_ce_n | output | 1 | Active-low memory chip enable |
| mem_wp | output | 1 | Memory write protect, active high |

## Verification
The bench builds two copies that share every input. One uses the full 12-bit bank field, which reaches page 0xFFF and shows the complement across all twelve upper lines. The other uses a 3-bit field, where most host address bits lie outside the field. Only this narrow copy can show that those bits are dropped and that inverted order wraps at page 7. Both copies see the same aborted cycles, address changes in mid-strobe and resets, so the ordering logic is checked at two widths against one stimulus.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_DRAIN = 2'd2
    } cbl_state_e;

    localparam int WIN_BITS = 13;

endpackage

// File: rtl/cbl_strobe_fsm.sv
module cbl_strobe_fsm
    import cbl_pkg::*;
#(
    parameter int BANK_BITS = 12,
    parameter int BANK_LSB  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN_BITS-1:0]  addr,
    input  logic                 sel_n,
    input  logic                 wr_n,
    output logic                 commit,
    output logic [BANK_BITS-1:0] pend_q,
    output cbl_state_e           state_q
);

    cbl_state_e state_d;
    logic       capture;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (!sel_n && !wr_n) begin
                    state_d = S_ARMED;
                end
            end
            S_ARMED: begin
                if (wr_n) begin
                    state_d = S_IDLE;
                end else if (sel_n) begin
                    state_d = S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (wr_n) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        capture = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            S_IDLE:  capture = !sel_n && !wr_n;
            S_ARMED: commit  = wr_n;
            S_DRAIN: ;
            default: ;
        endcase
    end

    // address field captured when the strobe is first seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (capture) begin
            pend_q <= addr[BANK_LSB +: BANK_BITS];
        end
    end

endmodule

// File: rtl/cbl_bank_reg.sv
module cbl_bank_reg #(
    parameter int BANK_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [BANK_BITS-1:0] next_bank,
    output logic [BANK_BITS-1:0] bank_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= next_bank;
        end
    end

endmodule

// File: rtl/cbl_page_map.sv
module cbl_page_map #(
    parameter int BANK_BITS = 12
) (
    input  logic [BANK_BITS-1:0] bank,
    input  logic                 invert,
    output logic [BANK_BITS-1:0] page
);

    // complement per line: page = (2^BANK_BITS - 1) - bank when inverted
    for (genvar i = 0; i < BANK_BITS; i++) begin : g_line
        assign page[i] = bank[i] ^ invert;
    end

endmodule

// File: rtl/cartbank_latch.sv
module cartbank_latch
    import cbl_pkg::*;
#(
    parameter int BANK_BITS = 12,
    parameter int BANK_LSB  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [12:0]                   host_addr,
    input  logic                          rom_cs_n,
    input  logic                          rom_we_n,
    input  logic                          inv_order,
    input  logic                          prog_en,
    output logic [BANK_BITS+13-1:0]       mem_addr,
    output logic                          mem_ce_n,
    output logic                          mem_wp
);

    localparam int MEM_AW = BANK_BITS + WIN_BITS;

    initial begin
        if (BANK_BITS < 1 || BANK_BITS > 12 || BANK_LSB + BANK_BITS > WIN_BITS) begin
            $error("cartbank_latch: bank field does not fit the window");
        end
    end

    logic                 commit;
    logic [BANK_BITS-1:0] pend_q;
    logic [BANK_BITS-1:0] bank_q;
    logic [BANK_BITS-1:0] page;
    cbl_state_e           fsm_state;

    cbl_strobe_fsm #(
        .BANK_BITS (BANK_BITS),
        .BANK_LSB  (BANK_LSB)
    ) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (host_addr),
        .sel_n   (rom_cs_n),
        .wr_n    (rom_we_n),
        .commit  (commit),
        .pend_q  (pend_q),
        .state_q (fsm_state)
    );

    cbl_bank_reg #(
        .BANK_BITS (BANK_BITS)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (commit),
        .next_bank (pend_q),
        .bank_q    (bank_q)
    );

    cbl_page_map #(
        .BANK_BITS (BANK_BITS)
    ) i_map (
        .bank   (bank_q),
        .invert (inv_order),
        .page   (page)
    );

    logic [MEM_AW-1:0] addr_out;
    assign addr_out = {page, host_addr};
    assign mem_addr = addr_out;
    assign mem_ce_n = rom_cs_n;
    assign mem_wp   = ~prog_en;

endmodule

// File: rtl/cartbank_latch_chk.sv
module cartbank_latch_chk
    import cbl_pkg::*;
#(
    parameter int BANK_BITS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rom_cs_n,
    input logic                 rom_we_n,
    input logic                 prog_en,
    input logic                 mem_wp,
    input cbl_state_e           state,
    input logic [BANK_BITS-1:0] bank_q,
    input logic [BANK_BITS-1:0] pend_q
);

    // R1: bank is 0 on the first edge after reset release
    a_r1_reset_bank: assert property (@(posedge clk)
        $rose(rst_n) |-> bank_q == '0);

    // R3: a committed bank is the one captured at the start of the strobe
    a_r3_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && rom_we_n) |=> bank_q == $past(pend_q));

    // R3: no change while the strobe is held low
    a_r3_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && !rom_we_n) |=> $stable(bank_q));

    // R9: the captured field stays fixed while armed
    a_r9_pend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED) |=> $stable(pend_q));

    // R6 and R7: the idle state never loads a bank
    a_r7_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> $stable(bank_q));

    // R8: dropped cycle goes to drain and loads nothing
    a_r8_abort_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && rom_cs_n && !rom_we_n) |=> (state == S_DRAIN && $stable(bank_q)));

    a_r8_drain_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN) |=> $stable(bank_q));

    // R11: programming enable lifts protection
    a_r11_wp: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !mem_wp);

endmodule

bind cartbank_latch cartbank_latch_chk #(
    .BANK_BITS (BANK_BITS)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_cs_n (rom_cs_n),
    .rom_we_n (rom_we_n),
    .prog_en  (prog_en),
    .mem_wp   (mem_wp),
    .state    (fsm_state),
    .bank_q   (bank_q),
    .pend_q   (pend_q)
);

// File: tb/test_cartbank_latch.sv
`timescale 1ns/1ps
module test_cartbank_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] host_addr = '0;
    logic        rom_cs_n = 1'b1;
    logic        rom_we_n = 1'b1;
    logic        inv_order = 1'b0;
    logic        prog_en = 1'b0;
    logic [24:0] mem_addr_w;
    logic [15:0] mem_addr_n;
    logic        ce_w, ce_n, wp_w, wp_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cartbank_latch i_cartbank_latch (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .rom_cs_n(rom_cs_n),
        .rom_we_n(rom_we_n), .inv_order(inv_order), .prog_en(prog_en),
        .mem_addr(mem_addr_w), .mem_ce_n(ce_w), .mem_wp(wp_w)
    );

    cartbank_latch #(.BANK_BITS(3), .BANK_LSB(1)) i_cartbank_latch_narrow (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .rom_cs_n(rom_cs_n),
        .rom_we_n(rom_we_n), .inv_order(inv_order), .prog_en(prog_en),
        .mem_addr(mem_addr_n), .mem_ce_n(ce_n), .mem_wp(wp_n)
    );

    // vectors: write address, order, expected wide page, expected narrow page
    localparam int NV = 8;
    localparam logic [12:0] V_ADDR [NV] = '{13'h0002, 13'h1FFE, 13'h0AAA, 13'h1000,
                                            13'h0002, 13'h0AAA, 13'h0001, 13'h0F10};
    localparam logic        V_INV  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [11:0] V_PGW  [NV] = '{12'h001, 12'hFFF, 12'h555, 12'h800,
                                            12'hFFE, 12'hAAA, 12'h000, 12'h877};
    localparam logic [2:0]  V_PGN  [NV] = '{3'd1, 3'd7, 3'd5, 3'd0, 3'd6, 3'd2, 3'd0, 3'd7};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pgw();
        return {4'h0, mem_addr_w[24:13]};
    endfunction

    function automatic logic [15:0] pgn();
        return {13'h0, mem_addr_n[15:13]};
    endfunction

    task automatic host_write(input logic [12:0] a);
        @(negedge clk); host_addr = a; rom_cs_n = 1'b0; rom_we_n = 1'b0;
        @(negedge clk); rom_cs_n = 1'b1; rom_we_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: state during reset, both orders
        repeat (3) @(negedge clk);
        check("R1 reset normal wide", pgw(), 16'h000);
        check("R1 reset normal narrow", pgn(), 16'h0);
        inv_order = 1'b1;
        #1;
        check("R1 reset inverted wide", pgw(), 16'hFFF);
        check("R1 reset inverted narrow", pgn(), 16'h7);
        inv_order = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", pgw(), 16'h000);

        // R2 R4 R10: table walk
        for (int k = 0; k < NV; k++) begin
            inv_order = V_INV[k];
            host_write(V_ADDR[k]);
            check("R2 R4 wide page", pgw(), {4'h0, V_PGW[k]});
            check("R10 R4 narrow page", pgn(), {13'h0, V_PGN[k]});
        end

        // R4: order switch applies without a clock (bank 0x788, narrow 0)
        inv_order = 1'b0;
        #1;
        check("R4 normal after switch", pgw(), 16'h788);
        check("R4 narrow after switch", pgn(), 16'h0);

        // R5 R6 R12: read cycle
        @(negedge clk); host_addr = 13'h0123; rom_cs_n = 1'b0; rom_we_n = 1'b1;
        #1;
        check("R5 offset passthrough", {3'b0, mem_addr_w[12:0]}, 16'h0123);
        check("R12 ce follows select low", {15'h0, ce_w}, 16'h0);
        repeat (2) @(negedge clk);
        check("R6 read keeps page", pgw(), 16'h788);
        rom_cs_n = 1'b1;
        #1;
        check("R12 ce follows select high", {15'h0, ce_w}, 16'h1);

        // R7: strobe outside the window
        @(negedge clk); host_addr = 13'h0002; rom_we_n = 1'b0;
        repeat (2) @(negedge clk);
        rom_we_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 outside write ignored", pgw(), 16'h788);

        // R8: select drops before strobe
        @(negedge clk); host_addr = 13'h0004; rom_cs_n = 1'b0; rom_we_n = 1'b0;
        @(negedge clk); rom_cs_n = 1'b1;
        @(negedge clk); rom_we_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 aborted write", pgw(), 16'h788);

        // R3 R9: address moves during strobe
        @(negedge clk); host_addr = 13'h0006; rom_cs_n = 1'b0; rom_we_n = 1'b0;
        @(negedge clk);
        check("R3 page held during strobe", pgw(), 16'h788);
        host_addr = 13'h0010;
        @(negedge clk);
        check("R3 page held longer strobe", pgw(), 16'h788);
        rom_cs_n = 1'b1; rom_we_n = 1'b1;
        @(negedge clk);
        check("R9 first address used wide", pgw(), 16'h003);
        check("R9 first address used narrow", pgn(), 16'h3);

        // R11: write protect
        check("R11 protected", {15'h0, wp_w}, 16'h1);
        prog_en = 1'b1;
        #1;
        check("R11 unprotected", {15'h0, wp_w}, 16'h0);
        prog_en = 1'b0;

        // R1: reset after a bank change, inverted order
        inv_order = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset inverted wide", pgw(), 16'hFFF);
        check("R1 re-reset inverted narrow", pgn(), 16'h7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule